// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the chip-side configuration port of a multi-function I/O device. The host reaches it through a two-byte window. Offset 0 is an index register and offset 1 is a data register. To read or write a configuration register, the host first writes its index to offset 0 and then reads or writes offset 1.

After reset the port is locked and answers nothing useful. It opens only after the host writes the open key 0x87 to the index register twice without any other index write in between. Writing the close key 0xAA to the index register locks the port again.

While the port is open it presents the following registers:

- a chip ID and a vendor ID, both read-only;
- a logical-device select register;
- a 16-bit I/O base address for each logical device. These are banked: indices 0x60 and 0x61 always refer to the device that is currently selected.

The current device number and every device's base address leave the block as registered outputs, for use by downstream address decode logic.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, `ldn_out` is 0 and `base_out` equals the `BASE_INIT` parameter, with device k in bits [16k+15:16k]. While locked, a read at either offset returns 0xFF.
- R2: Two index-register writes of 0x87 with no other index write between them open the port. Data-register writes made between the two keys neither count toward the sequence nor break it.
- R3: An index-register write of any value other than 0x87 while the port is not yet open restarts the key sequence. A single 0x87 write leaves the port locked.
- R4: While the port is open, an index-register write of 0xAA locks the port and is not taken as an index.
- R5: While the port is locked, data-register writes change no register: `ldn_out` and `base_out` hold, and the values read back after the next unlock are unchanged.
- R6: While the port is open, a read at offset 0 returns the current index and a read at offset 1 returns the register that index selects. `bus_rdata` is updated on the clock edge that samples `bus_rd` and holds its value until the next read.
- R7: Index 0x07 selects the logical device. A write stores the low `LDN_W` bits of the data, and reads return them zero-extended. `ldn_out` shows the new value from the edge that performs the write.
- R8: Indices 0x20 and 0x21 return the high and low bytes of the `CHIP_ID` parameter. Indices 0x23 and 0x24 return the high and low bytes of the vendor ID 0x1934. Writes to these four indices have no effect.
- R9: Indices 0x60 (high byte) and 0x61 (low byte) read and write the base address of the selected device. Each device keeps its own base address, which appears on its slice of `base_out`.
- R10: While the port is open, every index not listed in R7–R9 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Window offset: 0 = index register, 1 = data register |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ldn_out | output | LDN_W | Currently selected logical-device number |
| base_out | output | 16*NUM_DEV | Base address of every logical device, device 0 in the low bits |

## Verification
The hardest state to reach from the ports is a data-register write made while the port is locked: its target cannot be chosen, because the index register itself cannot be written until the port opens. The stimulus therefore first opens the port and points the index at the device-select register. It then locks the port, writes data, and reopens it. A stale index would then land that write, and reading back shows that it did not. The key sequence is also interrupted both by a stray index value and by a data write, to separate the two rules. Finally, a sweep over all 256 index values (skipping the close key) compares every read against values the bench computes from the device number and the per-device base pattern.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN    = 8'h87;
  localparam logic [7:0] KEY_CLOSE   = 8'hAA;
  localparam logic [7:0] IX_LDN      = 8'h07;
  localparam logic [7:0] IX_CHIP_HI  = 8'h20;
  localparam logic [7:0] IX_CHIP_LO  = 8'h21;
  localparam logic [7:0] IX_VEND_HI  = 8'h23;
  localparam logic [7:0] IX_VEND_LO  = 8'h24;
  localparam logic [7:0] IX_BASE_HI  = 8'h60;
  localparam logic [7:0] IX_BASE_LO  = 8'h61;
  localparam logic [7:0] LOCKED_READ = 8'hFF;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open
);
  key_state_t state_q, state_d;

  // Only writes to the index register affect the key sequence.
  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      unique case (state_q)
        KS_LOCKED: state_d = (wdata == KEY_OPEN) ? KS_HALF : KS_LOCKED;
        KS_HALF:   state_d = (wdata == KEY_OPEN) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   state_d = (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KS_LOCKED;
    else     state_q <= state_d;
  end

  assign cfg_open = (state_q == KS_OPEN);
endmodule

// File: rtl/sio_bar_bank.sv
module sio_bar_bank #(
  parameter int NUM_DEV = 8,
  parameter int LDN_W   = 3,
  parameter int BASE_W  = 16,
  parameter logic [NUM_DEV*BASE_W-1:0] BASE_INIT = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LDN_W-1:0]          sel,
  input  logic                      wr_hi,
  input  logic                      wr_lo,
  input  logic [7:0]                wdata,
  output logic [BASE_W-1:0]         rd_val,
  output logic [NUM_DEV*BASE_W-1:0] base_flat
);
  localparam int HALF_W = BASE_W / 2;

  logic [BASE_W-1:0] bases [NUM_DEV];

  // One base-address register per logical device, all visible at once.
  for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
    always_ff @(posedge clk) begin
      if (rst) begin
        bases[k] <= BASE_INIT[k*BASE_W +: BASE_W];
      end else if (sel == LDN_W'(k)) begin
        if (wr_hi) bases[k][BASE_W-1:HALF_W] <= wdata[HALF_W-1:0];
        if (wr_lo) bases[k][HALF_W-1:0]      <= wdata[HALF_W-1:0];
      end
    end
    assign base_flat[k*BASE_W +: BASE_W] = bases[k];
  end

  // Read port for the selected device; a number with no device reads 0.
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (sel == LDN_W'(i)) rd_val = bases[i];
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter logic [15:0] CHIP_ID   = 16'h0406,
  parameter logic [15:0] VENDOR_ID = 16'h1934,
  parameter logic [NUM_DEV*16-1:0] BASE_INIT =
    128'h0E00_0D00_0C00_0B00_0A00_0900_0800_0700,
  localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_addr,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic [LDN_W-1:0]      ldn_out,
  output logic [NUM_DEV*16-1:0] base_out
);
  logic       idx_wr, dat_wr, cfg_open;
  logic [7:0] index_q;
  logic [LDN_W-1:0] ldn_q;
  logic [15:0] sel_base;
  logic [7:0] reg_val;
  logic [7:0] rdata_q;
  logic       base_hi_wr, base_lo_wr;

  assign idx_wr = bus_wr && !bus_addr;
  assign dat_wr = bus_wr &&  bus_addr;

  sio_key_fsm u_key (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .wdata    (bus_wdata),
    .cfg_open (cfg_open)
  );

  // The index register only moves while the port is open, and never takes the close key.
  always_ff @(posedge clk) begin
    if (rst)
      index_q <= '0;
    else if (cfg_open && idx_wr && bus_wdata != KEY_CLOSE)
      index_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ldn_q <= '0;
    else if (cfg_open && dat_wr && index_q == IX_LDN)
      ldn_q <= bus_wdata[LDN_W-1:0];
  end

  assign base_hi_wr = cfg_open && dat_wr && (index_q == IX_BASE_HI);
  assign base_lo_wr = cfg_open && dat_wr && (index_q == IX_BASE_LO);

  sio_bar_bank #(
    .NUM_DEV   (NUM_DEV),
    .LDN_W     (LDN_W),
    .BASE_W    (16),
    .BASE_INIT (BASE_INIT)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .sel       (ldn_q),
    .wr_hi     (base_hi_wr),
    .wr_lo     (base_lo_wr),
    .wdata     (bus_wdata),
    .rd_val    (sel_base),
    .base_flat (base_out)
  );

  always_comb begin
    unique case (index_q)
      IX_LDN:     reg_val = 8'(ldn_q);
      IX_CHIP_HI: reg_val = CHIP_ID[15:8];
      IX_CHIP_LO: reg_val = CHIP_ID[7:0];
      IX_VEND_HI: reg_val = VENDOR_ID[15:8];
      IX_VEND_LO: reg_val = VENDOR_ID[7:0];
      IX_BASE_HI: reg_val = sel_base[15:8];
      IX_BASE_LO: reg_val = sel_base[7:0];
      default:    reg_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= LOCKED_READ;
    else if (bus_rd) begin
      if (!cfg_open)     rdata_q <= LOCKED_READ;
      else if (!bus_addr) rdata_q <= index_q;
      else               rdata_q <= reg_val;
    end
  end

  assign bus_rdata = rdata_q;
  assign ldn_out   = ldn_q;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int NUM_DEV = 8,
  parameter int LDN_W   = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_addr,
  input logic                  bus_rd,
  input logic                  bus_wr,
  input logic [7:0]            bus_wdata,
  input logic [7:0]            bus_rdata,
  input logic [LDN_W-1:0]      ldn_out,
  input logic [NUM_DEV*16-1:0] base_out,
  input logic                  cfg_open
);
  assert_ldn_zero_after_reset_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> ldn_out == '0);

  assert_locked_read_ff_R1: assert property (@(posedge clk) disable iff (rst)
    !cfg_open && bus_rd |=> bus_rdata == 8'hFF);

  assert_open_after_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87));

  assert_stray_index_relocks_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_open && bus_wr && !bus_addr && bus_wdata != 8'h87 |=> !cfg_open);

  assert_close_key_locks_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_open && bus_wr && !bus_addr && bus_wdata == 8'hAA |=> !cfg_open);

  assert_locked_write_inert_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_open && bus_wr |=> $stable(ldn_out) && $stable(base_out));

  assert_rdata_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .NUM_DEV (NUM_DEV),
  .LDN_W   (LDN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ldn_out   (ldn_out),
  .base_out  (base_out),
  .cfg_open  (cfg_open)
);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
  localparam int NDEV = 8;
  localparam logic [15:0] CHIP = 16'h0406;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] ldn_out;
  logic [NDEV*16-1:0] base_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_base [NDEV];
  logic [2:0]  exp_ldn;
  logic [7:0]  got;

  always #2.5 clk = ~clk;

  sio_cfg_port #(.NUM_DEV(NDEV), .CHIP_ID(CHIP)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ldn_out(ldn_out), .base_out(base_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic unlock();
    bus_write(1'b0, 8'h87);
    bus_write(1'b0, 8'h87);
  endtask

  function automatic logic [7:0] expect_reg(input int ix);
    case (ix)
      8'h07: return 8'(exp_ldn);
      8'h20: return CHIP[15:8];
      8'h21: return CHIP[7:0];
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      8'h60: return exp_base[exp_ldn][15:8];
      8'h61: return exp_base[exp_ldn][7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NDEV; k++) exp_base[k] = 16'((7 + k) << 8);
    exp_ldn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 ldn", 32'(ldn_out), 0);
    for (int k = 0; k < NDEV; k++)
      check("R1 base", 32'(base_out[k*16 +: 16]), 32'(exp_base[k]));
    bus_read(1'b1, got); check("R1 data locked", 32'(got), 32'hFF);
    bus_read(1'b0, got); check("R1 index locked", 32'(got), 32'hFF);

    // R3 single key, broken key
    bus_write(1'b0, 8'h87);
    bus_read(1'b1, got); check("R3 single key", 32'(got), 32'hFF);
    bus_write(1'b0, 8'h55);
    bus_write(1'b0, 8'h87);
    bus_read(1'b1, got); check("R3 broken key", 32'(got), 32'hFF);
    bus_write(1'b0, 8'h00);

    // R2 data write between keys does not break the sequence
    bus_write(1'b0, 8'h87);
    bus_write(1'b1, 8'h33);
    bus_write(1'b0, 8'h87);
    bus_write(1'b0, 8'h07);
    bus_read(1'b0, got); check("R2 open index", 32'(got), 32'h07);
    bus_read(1'b1, got); check("R2 ldn readable", 32'(got), 32'h00);

    // R7 ldn select and truncation
    bus_write(1'b1, 8'h05); exp_ldn = 3'd5;
    check("R7 ldn_out", 32'(ldn_out), 5);
    bus_write(1'b1, 8'h0B); exp_ldn = 3'd3;
    check("R7 truncate", 32'(ldn_out), 3);
    bus_read(1'b1, got); check("R7 readback", 32'(got), 32'h03);

    // R6 rdata holds between reads
    repeat (3) @(negedge clk);
    check("R6 hold", 32'(bus_rdata), 32'h03);

    // R4 close key, index not taken; R5 locked data write inert
    bus_write(1'b0, 8'hAA);
    bus_read(1'b0, got); check("R4 locked index", 32'(got), 32'hFF);
    bus_write(1'b1, 8'h06);
    check("R5 ldn held", 32'(ldn_out), 3);
    unlock();
    bus_read(1'b0, got); check("R4 index kept", 32'(got), 32'h07);
    bus_read(1'b1, got); check("R5 ldn unchanged", 32'(got), 32'h03);

    // R9 per-device base sweep
    for (int k = 0; k < NDEV; k++) begin
      logic [15:0] v;
      v = 16'((k * 16'h1357 + 16'h0A21) & 16'hFFFF);
      bus_write(1'b0, 8'h07); bus_write(1'b1, 8'(k)); exp_ldn = 3'(k);
      bus_write(1'b0, 8'h60); bus_write(1'b1, v[15:8]);
      bus_write(1'b0, 8'h61); bus_write(1'b1, v[7:0]);
      exp_base[k] = v;
    end
    for (int k = 0; k < NDEV; k++) begin
      check("R9 base_out", 32'(base_out[k*16 +: 16]), 32'(exp_base[k]));
      bus_write(1'b0, 8'h07); bus_write(1'b1, 8'(k)); exp_ldn = 3'(k);
      bus_write(1'b0, 8'h60); bus_read(1'b1, got);
      check("R9 hi", 32'(got), 32'(exp_base[k][15:8]));
      bus_write(1'b0, 8'h61); bus_read(1'b1, got);
      check("R9 lo", 32'(got), 32'(exp_base[k][7:0]));
    end

    // R8 ID writes ignored
    bus_write(1'b0, 8'h20); bus_write(1'b1, 8'h55);
    bus_read(1'b1, got); check("R8 chip hi", 32'(got), 32'(CHIP[15:8]));
    bus_write(1'b0, 8'h24); bus_write(1'b1, 8'h00);
    bus_read(1'b1, got); check("R8 vendor lo", 32'(got), 32'h34);

    // R10 / R6 full index sweep, device 5 selected
    bus_write(1'b0, 8'h07); bus_write(1'b1, 8'h05); exp_ldn = 3'd5;
    for (int ix = 0; ix < 256; ix++) begin
      if (ix == 8'hAA) continue;
      bus_write(1'b0, 8'(ix));
      bus_read(1'b1, got);
      check("R10 sweep", 32'(got), 32'(expect_reg(ix)));
    end

    finish_run();
  end
endmodule